// File: doc/BRIEF.md
# Prioritized-Vector Interrupt Controller

This block is the interrupt logic of a small 8-bit microcontroller core. It holds the control/flag register: a global enable, a peripheral-group enable, and an enable and a sticky flag for each of three core sources. The three core sources are a timer wrap, an edge on an external pin and a change on four upper port pins. A second register pair holds eight peripheral flags and their enables. Software reads and writes all three registers over a simple register bus. Hardware only ever sets flags. Software clears them.

An internal four-phase counter divides the clock into instruction cycles. Each instruction cycle runs through Q1, Q2, Q3 and Q4, one clock per phase. At every Q1 the block samples the pending state. It raises a wake request whenever any enabled source is pending, whatever the global enable holds. When the global enable is also set, it clears the global enable and requests a branch to vector 0x0004 with a fixed latency. A return-from-interrupt strobe from the core sets the global enable again. The timer and the peripherals appear only as one-clock event pulses.

Top module: `irq_ctl_core`

## Requirements
- R1: Reset clears control bits [7:1], the peripheral flag register and the peripheral enable register. Reset leaves control bit 0 (port-change flag) and the latched port reference unchanged.
- R2: Register address 0 selects the control register, 1 the peripheral flags, 2 the peripheral enables, and 3 reads as 0x00. A write takes effect at the clock edge in which `reg_wr_i` is high. Reads are combinational.
- R3: The control register bits, from bit 7 down to bit 0, are: global enable, peripheral enable, timer enable, pin enable, port enable, timer flag, pin flag, port flag. After a two-flop synchronizer, the pin flag (bit 1) is set by a rising edge when `ext_rise_sel_i`=1 and by a falling edge when it is 0. The opposite edge does not set it.
- R4: A `tmr_wrap_i` pulse sets the timer flag (bit 2).
- R5: The synchronized port bits are compared with the value latched at the last `port_rd_i` strobe. A mismatch sets the port flag (bit 0), and keeps setting it until a read strobe latches the new value. A mismatch whose first cycle coincides with a read strobe is lost.
- R6: Hardware never clears a flag. A hardware set in the same clock as a software write of 0 wins.
- R7: A `per_evt_i[i]` pulse sets peripheral flag i. Peripheral flag bit 3 is unused: it reads 0, and neither events nor writes can set it.
- R8: An interrupt is pending when any core flag is set together with its enable, or when the peripheral enable is set and any peripheral flag is set together with its enable. `wake_o` is loaded with the pending state at every Q1, whatever the global enable holds.
- R9: If a source is pending and the global enable is 1 at the Q1 of instruction cycle N, the global enable clears at that edge. `vec_req_o` is then high for exactly the four clocks of cycle N+2, starting at its Q1, and `vec_addr_o` is 0x0004.
- R10: With the global enable at 0, a pending source raises `wake_o` but never raises `vec_req_o`.
- R11: A `reti_i` pulse sets the global enable.
- R12: `q_phase_o` is 0 (Q1) out of reset and steps 0,1,2,3,0 by one each clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one per phase |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr_i | input | 2 | Register select |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data (combinational) |
| tmr_wrap_i | input | 1 | Timer wrapped from 0xFF to 0x00, one-clock pulse |
| ext_pin_i | input | 1 | Asynchronous external interrupt pin |
| ext_rise_sel_i | input | 1 | 1 selects rising edge, 0 selects falling edge |
| port_hi_i | input | 4 | Asynchronous upper port pins |
| port_rd_i | input | 1 | Port read strobe, latches the reference |
| per_evt_i | input | 8 | Peripheral event pulses |
| reti_i | input | 1 | Return-from-interrupt strobe |
| q_phase_o | output | 2 | Current phase, 0 = Q1 to 3 = Q4 |
| wake_o | output | 1 | Wake request |
| vec_req_o | output | 1 | Vector request, one instruction cycle long |
| vec_addr_o | output | 13 | Vector address |

## Verification
The assertions take for granted that software neither writes the global enable nor pulses `reti_i` while a vector request is in flight. They also assume the external pin is low when reset is released, so the synchronizer does not see a false edge, and that bus writes happen only outside reset. The bench follows all three rules. It clears every flag before it sets the global enable, drives each input on a falling edge, and keeps the pin low across every reset.

// File: rtl/irq_pkg.sv
// Shared definitions for the interrupt controller: phase encoding,
// register addresses and control-register bit positions.
// Assumes a four-phase instruction cycle, one clock per phase.
package irq_pkg;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } qphase_t;

    localparam logic [1:0] A_CTL   = 2'd0;
    localparam logic [1:0] A_PFLAG = 2'd1;
    localparam logic [1:0] A_PEN   = 2'd2;

    localparam int unsigned B_GIE  = 7;
    localparam int unsigned B_PEIE = 6;
    localparam int unsigned B_TEN  = 5;
    localparam int unsigned B_XEN  = 4;
    localparam int unsigned B_PEN  = 3;
    localparam int unsigned B_TF   = 2;
    localparam int unsigned B_XF   = 1;
    localparam int unsigned B_PF   = 0;

endpackage

// File: rtl/irq_qphase.sv
// Phase generator: splits the clock into instruction cycles of four
// phases, Q1..Q4, one clock each. Assumes a free-running clock.
module irq_qphase
    import irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    output qphase_t ph_o,
    output logic    q1_o,
    output logic    q4_o
);

    qphase_t ph_q;

    // Step the phase once per clock, wrapping Q4 back to Q1.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_Q1;
        else        ph_q <= qphase_t'(ph_q + 2'd1);
    end

    assign ph_o = ph_q;
    assign q1_o = (ph_q == PH_Q1);
    assign q4_o = (ph_q == PH_Q4);

endmodule

// File: rtl/irq_evt_det.sv
// Event detector: synchronizes the external pin and the upper port pins,
// finds the selected edge on the pin and a mismatch of the port against
// the value latched at the last port read. Port state is not reset so
// that a reset leaves the port-change condition as it was.
module irq_evt_det #(
    parameter int unsigned PORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_i,
    input  logic              rise_sel_i,
    input  logic [PORT_W-1:0] port_i,
    input  logic              port_rd_i,
    output logic              pin_edge_o,
    output logic              port_chg_o
);

    logic              pin_s1, pin_s2, pin_d;
    logic [PORT_W-1:0] port_s1, port_s2, port_ref;

    // Two-flop synchronizer for the pin, plus a delayed copy for edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_s1 <= 1'b0;
            pin_s2 <= 1'b0;
            pin_d  <= 1'b0;
        end else begin
            pin_s1 <= pin_i;
            pin_s2 <= pin_s1;
            pin_d  <= pin_s2;
        end
    end

    // Port synchronizer and read reference; kept across reset.
    always_ff @(posedge clk) begin
        port_s1 <= port_i;
        port_s2 <= port_s1;
        if (port_rd_i) port_ref <= port_s2;
    end

    assign pin_edge_o = rise_sel_i ? (pin_s2 & ~pin_d) : (~pin_s2 & pin_d);
    // A read in the same cycle overwrites the reference and masks the event.
    assign port_chg_o = (port_s2 != port_ref) && !port_rd_i;

endmodule

// File: rtl/irq_vec_seq.sv
// Vector sequencer: samples the pending state at Q1, drives the wake
// request and, when the global enable allows, counts a fixed latency in
// instruction cycles before a one-cycle vector request. Assumes
// LAT_CYC >= 2.
module irq_vec_seq #(
    parameter int unsigned LAT_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic q1_i,
    input  logic q4_i,
    input  logic pend_i,
    input  logic gie_i,
    output logic take_o,
    output logic vec_req_o,
    output logic wake_o
);

    localparam int unsigned CNT_W = $clog2(LAT_CYC + 1);

    logic             busy_q, vec_q, wake_q;
    logic [CNT_W-1:0] cnt_q;

    assign take_o = q1_i && gie_i && pend_i && !busy_q;

    // Sample wake at Q1 and run the latency count at each Q4.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            vec_q  <= 1'b0;
            wake_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (q1_i) wake_q <= pend_i;
            if (take_o) begin
                busy_q <= 1'b1;
                cnt_q  <= CNT_W'(LAT_CYC - 1);
            end else if (busy_q && q4_i) begin
                if (vec_q) begin
                    vec_q  <= 1'b0;
                    busy_q <= 1'b0;
                end else begin
                    if (cnt_q == CNT_W'(1)) vec_q <= 1'b1;
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end
        end
    end

    assign vec_req_o = vec_q;
    assign wake_o    = wake_q;

endmodule

// File: rtl/irq_ctl_core.sv
// Interrupt controller top: control/flag register, peripheral flag and
// enable registers, pending logic, register bus, and the phase, event
// and vector submodules. Assumes event pulses are synchronous to clk and
// one clock wide; the pin and the port may be asynchronous.
module irq_ctl_core
    import irq_pkg::*;
#(
    parameter int unsigned PORT_W    = 4,
    parameter int unsigned PERI_W    = 8,
    parameter logic [7:0]  PERI_USED = 8'hF7,
    parameter int unsigned LAT_CYC   = 3,
    parameter int unsigned VEC_W     = 13,
    parameter logic [12:0] VEC_ADDR  = 13'h0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [7:0]        reg_wdata_i,
    output logic [7:0]        reg_rdata_o,
    input  logic              tmr_wrap_i,
    input  logic              ext_pin_i,
    input  logic              ext_rise_sel_i,
    input  logic [PORT_W-1:0] port_hi_i,
    input  logic              port_rd_i,
    input  logic [PERI_W-1:0] per_evt_i,
    input  logic              reti_i,
    output logic [1:0]        q_phase_o,
    output logic              wake_o,
    output logic              vec_req_o,
    output logic [VEC_W-1:0]  vec_addr_o
);

    qphase_t ph;
    logic    q1, q4, pin_edge, port_chg, take, pend_any;
    logic    ctl_wr, pfl_wr, pen_wr;
    logic    gie_q, peie_q, ten_q, xen_q, pen_q, tflag_q, xflag_q, pflag_q;
    logic [PERI_W-1:0] pfl_q, pie_q;

    irq_qphase u_ph (
        .clk(clk), .rst_n(rst_n), .ph_o(ph), .q1_o(q1), .q4_o(q4)
    );

    irq_evt_det #(.PORT_W(PORT_W)) u_det (
        .clk(clk), .rst_n(rst_n), .pin_i(ext_pin_i),
        .rise_sel_i(ext_rise_sel_i), .port_i(port_hi_i),
        .port_rd_i(port_rd_i), .pin_edge_o(pin_edge),
        .port_chg_o(port_chg)
    );

    irq_vec_seq #(.LAT_CYC(LAT_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .q1_i(q1), .q4_i(q4),
        .pend_i(pend_any), .gie_i(gie_q), .take_o(take),
        .vec_req_o(vec_req_o), .wake_o(wake_o)
    );

    assign ctl_wr = reg_wr_i && (reg_addr_i == A_CTL);
    assign pfl_wr = reg_wr_i && (reg_addr_i == A_PFLAG);
    assign pen_wr = reg_wr_i && (reg_addr_i == A_PEN);

    // Control register: enables, global enable and the reset-cleared flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q   <= 1'b0;
            peie_q  <= 1'b0;
            ten_q   <= 1'b0;
            xen_q   <= 1'b0;
            pen_q   <= 1'b0;
            tflag_q <= 1'b0;
            xflag_q <= 1'b0;
        end else begin
            if (take)        gie_q <= 1'b0;
            else if (reti_i) gie_q <= 1'b1;
            else if (ctl_wr) gie_q <= reg_wdata_i[B_GIE];
            if (ctl_wr) begin
                peie_q <= reg_wdata_i[B_PEIE];
                ten_q  <= reg_wdata_i[B_TEN];
                xen_q  <= reg_wdata_i[B_XEN];
                pen_q  <= reg_wdata_i[B_PEN];
            end
            if (tmr_wrap_i)  tflag_q <= 1'b1;
            else if (ctl_wr) tflag_q <= reg_wdata_i[B_TF];
            if (pin_edge)    xflag_q <= 1'b1;
            else if (ctl_wr) xflag_q <= reg_wdata_i[B_XF];
        end
    end

    // Port-change flag: hardware set or software write; kept across reset.
    always_ff @(posedge clk) begin
        if (port_chg)    pflag_q <= 1'b1;
        else if (ctl_wr) pflag_q <= reg_wdata_i[B_PF];
    end

    // One flag/enable pair per peripheral source; unused bits stay zero.
    for (genvar i = 0; i < PERI_W; i++) begin : g_peri
        logic f_q, e_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                f_q <= 1'b0;
                e_q <= 1'b0;
            end else begin
                if (per_evt_i[i])  f_q <= PERI_USED[i];
                else if (pfl_wr)   f_q <= PERI_USED[i] & reg_wdata_i[i];
                if (pen_wr)        e_q <= PERI_USED[i] & reg_wdata_i[i];
            end
        end
        assign pfl_q[i] = f_q;
        assign pie_q[i] = e_q;
    end

    assign pend_any = (ten_q & tflag_q) | (xen_q & xflag_q) | (pen_q & pflag_q)
                    | (peie_q & |(pfl_q & pie_q));

    // Register read mux.
    always_comb begin
        case (reg_addr_i)
            A_CTL:   reg_rdata_o = {gie_q, peie_q, ten_q, xen_q, pen_q,
                                    tflag_q, xflag_q, pflag_q};
            A_PFLAG: reg_rdata_o = pfl_q;
            A_PEN:   reg_rdata_o = pie_q;
            default: reg_rdata_o = 8'h00;
        endcase
    end

    assign q_phase_o  = ph;
    assign vec_addr_o = VEC_W'(VEC_ADDR);

endmodule

// File: rtl/irq_ctl_chk.sv
// Checker for irq_ctl_core: phase stepping, vector request shape, wake
// tracking, flag stickiness and the unused peripheral bit. Assumes no
// global-enable write or return strobe while a vector is in flight.
module irq_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] q_phase,
    input logic       vec_req,
    input logic       wake,
    input logic       gie,
    input logic       xflag,
    input logic       pend,
    input logic       ctl_wr,
    input logic [1:0] rd_addr,
    input logic [7:0] rdata
);

    logic armed;

    // Marks the clocks that have a post-reset cycle behind them.
    always_ff @(posedge clk) armed <= rst_n;

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> q_phase == 2'($past(q_phase) + 2'd1)); // R12
    AST_VEC_AT_Q1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_req) |-> q_phase == 2'd0); // R9
    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && q_phase != 2'd3) |=> vec_req); // R9
    AST_VEC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && q_phase == 2'd3) |=> !vec_req); // R9
    AST_VEC_GIE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> !gie); // R10
    AST_WAKE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (q_phase == 2'd0 && pend) |=> wake); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(xflag) && !$past(ctl_wr)) |-> xflag); // R6
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr == 2'd1 |-> rdata[3] == 1'b0); // R7

endmodule

bind irq_ctl_core irq_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .q_phase(q_phase_o), .vec_req(vec_req_o),
    .wake(wake_o), .gie(gie_q), .xflag(xflag_q), .pend(pend_any),
    .ctl_wr(ctl_wr), .rd_addr(reg_addr_i), .rdata(reg_rdata_o)
);

// File: tb/sim_irq_ctl_core.sv
module sim_irq_ctl_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       tmr_wrap = 1'b0;
    logic       ext_pin = 1'b0;
    logic       rise_sel = 1'b1;
    logic [3:0] port_hi = 4'h0;
    logic       port_rd = 1'b0;
    logic [7:0] per_evt = 8'h00;
    logic       reti = 1'b0;
    logic [1:0] q_phase;
    logic       wake, vec_req;
    logic [12:0] vec_addr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_ctl_core u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .tmr_wrap_i(tmr_wrap), .ext_pin_i(ext_pin),
        .ext_rise_sel_i(rise_sel), .port_hi_i(port_hi),
        .port_rd_i(port_rd), .per_evt_i(per_evt), .reti_i(reti),
        .q_phase_o(q_phase), .wake_o(wake), .vec_req_o(vec_req),
        .vec_addr_o(vec_addr)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_ph(input logic [1:0] p);
        while (q_phase != p) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R12 phase at release", q_phase, 0);
        for (int i = 1; i <= 4; i++) begin
            tick(1);
            check("R12 phase step", q_phase, i % 4);
        end
        bus_rd(2'd0, d); check("R1 ctl[7:1]", d & 8'hFE, 0);
        bus_rd(2'd1, d); check("R1 pflags", d, 0);
        bus_rd(2'd2, d); check("R1 penables", d, 0);
        check("R9 vector address", vec_addr, 13'h0004);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        bus_wr(2'd0, 8'h78);
        bus_rd(2'd0, d); check("R2 ctl enables", d & 8'hF8, 8'h78);
        bus_wr(2'd2, 8'h5A);
        bus_rd(2'd2, d); check("R2 pen readback", d, 8'h52);
        bus_wr(2'd3, 8'hFF);
        bus_rd(2'd3, d); check("R2 addr3 reads zero", d, 0);
        bus_wr(2'd2, 8'h00);
        bus_wr(2'd0, 8'h00);
    endtask

    task automatic t_ext();
        logic [7:0] d;
        rise_sel = 1'b1; ext_pin = 1'b1; tick(4);
        bus_rd(2'd0, d); check("R3 rising sets pin flag", d[1], 1);
        bus_wr(2'd0, 8'h00);
        ext_pin = 1'b0; tick(4);
        bus_rd(2'd0, d); check("R3 falling ignored when rise selected", d[1], 0);
        rise_sel = 1'b0; ext_pin = 1'b1; tick(4);
        bus_rd(2'd0, d); check("R3 rising ignored when fall selected", d[1], 0);
        ext_pin = 1'b0; tick(4);
        bus_rd(2'd0, d); check("R3 falling sets pin flag", d[1], 1);
        bus_wr(2'd0, 8'h00);
        rise_sel = 1'b1;
    endtask

    task automatic t_timer();
        logic [7:0] d;
        tmr_wrap = 1'b1; tick(1); tmr_wrap = 1'b0;
        bus_rd(2'd0, d); check("R4 timer flag", d[2], 1);
        bus_wr(2'd0, 8'h00);
    endtask

    task automatic t_port();
        logic [7:0] d;
        port_hi = 4'h5; tick(4);
        bus_rd(2'd0, d); check("R5 change sets port flag", d[0], 1);
        bus_wr(2'd0, 8'h00); tick(2);
        bus_rd(2'd0, d); check("R5 mismatch re-sets flag", d[0], 1);
        port_rd = 1'b1; tick(1); port_rd = 1'b0;
        bus_wr(2'd0, 8'h00); tick(3);
        bus_rd(2'd0, d); check("R5 cleared after read", d[0], 0);
        port_hi = 4'hA; tick(2);
        port_rd = 1'b1; tick(1); port_rd = 1'b0; tick(4);
        bus_rd(2'd0, d); check("R5 change lost during read", d[0], 0);
    endtask

    task automatic t_sticky();
        logic [7:0] d;
        tmr_wrap = 1'b1; tick(1); tmr_wrap = 1'b0;
        bus_wr(2'd0, 8'h04);
        tick(6);
        bus_rd(2'd0, d); check("R6 flag held with source disabled", d[2], 1);
        bus_wr(2'd0, 8'h00);
        reg_addr = 2'd0; reg_wdata = 8'h00; reg_wr = 1'b1; tmr_wrap = 1'b1;
        tick(1);
        reg_wr = 1'b0; tmr_wrap = 1'b0;
        bus_rd(2'd0, d); check("R6 hw set beats write of 0", d[2], 1);
        bus_wr(2'd0, 8'h00);
    endtask

    task automatic t_peri();
        logic [7:0] d;
        bus_wr(2'd2, 8'h01);
        per_evt = 8'h01; tick(1); per_evt = 8'h00;
        bus_rd(2'd1, d); check("R7 peripheral flag set", d, 8'h01);
        tick(5); check("R8 no wake without peripheral enable", wake, 0);
        bus_wr(2'd0, 8'h40); tick(5);
        check("R8 wake with peripheral enable", wake, 1);
        per_evt = 8'h08; tick(1); per_evt = 8'h00;
        bus_rd(2'd1, d); check("R7 unused bit event ignored", d, 8'h01);
        bus_wr(2'd1, 8'hFF);
        bus_rd(2'd1, d); check("R7 unused bit write ignored", d, 8'hF7);
        bus_wr(2'd1, 8'h00);
        bus_wr(2'd2, 8'h00);
        bus_wr(2'd0, 8'h00);
        tick(5); check("R8 wake drops when nothing pending", wake, 0);
    endtask

    task automatic t_nogie();
        int seen = 0;
        bus_wr(2'd0, 8'h10);
        ext_pin = 1'b1;
        for (int i = 0; i < 20; i++) begin
            tick(1);
            if (vec_req) seen++;
        end
        check("R8 wake with global enable off", wake, 1);
        check("R10 no vector with global enable off", seen, 0);
        ext_pin = 1'b0; tick(4);
        bus_wr(2'd0, 8'h00);
    endtask

    task automatic t_vector();
        logic [7:0] d;
        bus_wr(2'd0, 8'hA0);
        wait_ph(2'd2);
        tmr_wrap = 1'b1; tick(1); tmr_wrap = 1'b0;
        tick(1); check("R9 no vector at sample", vec_req, 0);
        tick(1);
        bus_rd(2'd0, d); check("R9 global enable cleared", d[7], 0);
        check("R8 wake after sample", wake, 1);
        tick(6); check("R9 vector not early", vec_req, 0);
        tick(1); check("R9 vector rises", vec_req, 1);
        check("R9 vector at Q1", q_phase, 0);
        tick(3); check("R9 vector held", vec_req, 1);
        tick(1); check("R9 vector one cycle", vec_req, 0);
    endtask

    task automatic t_reti();
        logic [7:0] d;
        bus_wr(2'd0, 8'h20);
        reti = 1'b1; tick(1); reti = 1'b0;
        bus_rd(2'd0, d); check("R11 return sets global enable", d[7], 1);
        bus_wr(2'd0, 8'h00);
    endtask

    task automatic t_rst_keep();
        logic [7:0] d;
        port_hi = 4'h3; tick(4);
        port_rd = 1'b1; tick(1); port_rd = 1'b0;
        bus_wr(2'd0, 8'h79);
        rst_n = 1'b0; tick(3); rst_n = 1'b1;
        bus_rd(2'd0, d); check("R1 reset keeps port flag only", d, 8'h01);
        bus_wr(2'd0, 8'h00);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_ext();
        t_timer();
        t_port();
        t_sticky();
        t_peri();
        t_nogie();
        t_vector();
        t_reti();
        t_rst_keep();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule